// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a physical address after a translation cache miss. It starts at the frame number of the top-level table and follows a chain of pointers through four table levels. It issues one 8-byte memory read per level over a valid/ready request port, and each read's data comes back on a valid-only response. Every fetched entry gives the frame of the next table. The last entry gives the frame of the page.

If the walk meets an entry whose present flag is clear, it stops at once and pulses a fault output that carries the level where it stopped. If the walk succeeds and the leaf's accessed flag was clear, the walker writes the leaf back with that flag set before it reports completion. The result is given as a one-cycle fill pulse that carries the original virtual address, the frame number and the full physical address, so that it can be installed in the translation cache. The low 12 address bits pass through unchanged.

Entry layout: bit 0 is the present flag, bit 5 is the accessed flag, and bits 51:12 hold the next-table frame or the page frame. The level indices are virtual address bits 47:39 (level 0), 38:30 (level 1), 29:21 (level 2) and 20:12 (level 3).

Top module: `page_walker`

## Requirements
- R1: `req_ready_o` is high only while the walker is idle. `busy_o` is high from the cycle after a request is accepted until the cycle in which `fill_valid_o` or `fault_o` pulses, and it is low in that cycle. The request inputs are captured on acceptance, so later changes to them do not affect the walk.
- R2: The first read address is `{root_ppn_i,12'h000} + 8*va[47:39]`.
- R3: The read at level k (k = 1..3) has address `{pte_prev[51:12],12'h000} + 8*index_k`, where index_k is va[38:30], va[29:21] or va[20:12] for k = 1, 2 or 3.
- R4: A walk that succeeds performs exactly four reads, in level order. At most one read is outstanding at a time, and no memory request is made while the walker is idle.
- R5: On success, `fill_ppn_o` equals bits 51:12 of the leaf entry, `fill_pa_o` equals `{fill_ppn_o, va[11:0]}`, and `fill_va_o` equals the virtual address of the request.
- R6: If the entry read at level k has bit 0 clear, `fault_o` pulses with `fault_level_o` = k. In that case the walk makes exactly k+1 reads, makes no write and does not pulse a fill.
- R7: If the leaf entry has bit 5 clear, exactly one write (`mem_req_we_o`=1) goes to the leaf address with data equal to the leaf entry with bit 5 set, and this write is accepted before the fill pulse. If bit 5 is already set, no write is made.
- R8: While `mem_req_valid_o` is high and `mem_req_ready_i` is low, the request stays valid and its address, write enable and data do not change.
- R9: `fill_valid_o` and `fault_o` each last one cycle and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Walk request |
| req_va_i | input | 48 | Virtual address to translate |
| root_ppn_i | input | 40 | Frame number of the top-level table |
| req_ready_o | output | 1 | Walker idle; the request is accepted |
| busy_o | output | 1 | Walk in progress |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_we_o | output | 1 | 1 = write of the leaf entry, 0 = read |
| mem_req_addr_o | output | 52 | Physical byte address of the entry |
| mem_req_wdata_o | output | 64 | Write data |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Read entry |
| fill_valid_o | output | 1 | Translation complete (one-cycle pulse) |
| fill_va_o | output | 48 | Translated virtual address |
| fill_ppn_o | output | 40 | Page frame number |
| fill_pa_o | output | 52 | Physical address |
| fault_o | output | 1 | Non-present entry found (one-cycle pulse) |
| fault_level_o | output | 2 | Level of the non-present entry |

## Verification
A wrong level counter or table base shows up at the ports on the very next read request: the address breaks the index formula, or the count of reads per walk changes. A flawed present-flag decision shows within one response: the walk issues a read after a fault, or it ends without one. A wrong accessed-flag path appears as a missing, duplicated or late write compared with the fill pulse. Random ready stalls and response delays test that requests are held stable and that one read at a time is outstanding.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W         = 48;
  localparam int OFF_W        = 12;
  localparam int PPN_W        = 40;
  localparam int PA_W         = PPN_W + OFF_W;
  localparam int PTE_W        = 64;
  localparam int LEVELS       = 4;
  localparam int IDX_W        = 9;
  localparam int PTE_BYTES_LG = 3;
  localparam int PRESENT_BIT  = 0;
  localparam int ACCESSED_BIT = 5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WAIT,
    ST_WB
  } ptw_state_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int PA_W         = 52,
  parameter int PPN_W        = 40,
  parameter int OFF_W        = 12,
  parameter int IDX_W        = 9,
  parameter int LEVELS       = 4,
  parameter int PTE_BYTES_LG = 3,
  localparam int LVL_W       = $clog2(LEVELS),
  localparam int VPN_W       = IDX_W * LEVELS
) (
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [PPN_W-1:0] base_ppn_i,
  output logic [PA_W-1:0]  addr_o
);
  logic [IDX_W-1:0] idx_tbl [LEVELS];

  // level 0 takes the most significant index
  for (genvar l = 0; l < LEVELS; l++) begin : g_idx
    assign idx_tbl[l] = vpn_i[IDX_W*(LEVELS-l)-1 -: IDX_W];
  end

  assign addr_o = {base_ppn_i, {OFF_W{1'b0}}}
                + (PA_W'(idx_tbl[level_i]) << PTE_BYTES_LG);
endmodule

// File: rtl/ptw_pte_dec.sv
module ptw_pte_dec #(
  parameter int PTE_W        = 64,
  parameter int PPN_W        = 40,
  parameter int OFF_W        = 12,
  parameter int PRESENT_BIT  = 0,
  parameter int ACCESSED_BIT = 5
) (
  input  logic [PTE_W-1:0] pte_i,
  output logic             present_o,
  output logic             accessed_o,
  output logic [PPN_W-1:0] next_ppn_o,
  output logic [PTE_W-1:0] marked_o
);
  assign present_o  = pte_i[PRESENT_BIT];
  assign accessed_o = pte_i[ACCESSED_BIT];
  assign next_ppn_o = pte_i[OFF_W+PPN_W-1:OFF_W];
  assign marked_o   = pte_i | (PTE_W'(1) << ACCESSED_BIT);
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int VA_W    = 48,
  parameter int PPN_W   = 40,
  parameter int PTE_W   = 64,
  parameter int LEVELS  = 4,
  localparam int LVL_W  = $clog2(LEVELS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_va_i,
  input  logic [PPN_W-1:0] root_ppn_i,
  output logic             req_ready_o,
  output logic             busy_o,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic             mem_req_we_o,
  input  logic             mem_rsp_valid_i,
  input  logic             pte_present_i,
  input  logic             pte_accessed_i,
  input  logic [PPN_W-1:0] pte_next_ppn_i,
  input  logic [PTE_W-1:0] pte_marked_i,
  output logic [PTE_W-1:0] wdata_o,
  output logic [VA_W-1:0]  va_o,
  output logic [LVL_W-1:0] level_o,
  output logic [PPN_W-1:0] base_o,
  output logic             fill_valid_o,
  output logic [PPN_W-1:0] fill_ppn_o,
  output logic             fault_o,
  output logic [LVL_W-1:0] fault_level_o
);
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  ptw_state_e st_q;

  assign req_ready_o     = (st_q == ST_IDLE);
  assign busy_o          = (st_q != ST_IDLE);
  assign mem_req_valid_o = (st_q == ST_RD) || (st_q == ST_WB);
  assign mem_req_we_o    = (st_q == ST_WB);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= ST_IDLE;
      va_o          <= '0;
      level_o       <= '0;
      base_o        <= '0;
      wdata_o       <= '0;
      fill_valid_o  <= 1'b0;
      fill_ppn_o    <= '0;
      fault_o       <= 1'b0;
      fault_level_o <= '0;
    end else begin
      fill_valid_o <= 1'b0;
      fault_o      <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          va_o    <= req_va_i;
          base_o  <= root_ppn_i;
          level_o <= '0;
          st_q    <= ST_RD;
        end
        ST_RD: if (mem_req_ready_i) st_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid_i) begin
          if (!pte_present_i) begin
            fault_o       <= 1'b1;
            fault_level_o <= level_o;
            st_q          <= ST_IDLE;
          end else if (level_o == LAST_LVL) begin
            fill_ppn_o <= pte_next_ppn_i;
            if (!pte_accessed_i) begin
              wdata_o <= pte_marked_i;
              st_q    <= ST_WB;
            end else begin
              fill_valid_o <= 1'b1;
              st_q         <= ST_IDLE;
            end
          end else begin
            base_o  <= pte_next_ppn_i;  // pointer chase
            level_o <= level_o + LVL_W'(1);
            st_q    <= ST_RD;
          end
        end
        ST_WB: if (mem_req_ready_i) begin
          fill_valid_o <= 1'b1;
          st_q         <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fill_valid_o && fault_o)) else $error("fill and fault together"); // R9
  AST_FILL_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_o |=> !fill_valid_o) else $error("fill longer than a cycle"); // R9
  AST_FAULT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !fault_o) else $error("fault longer than a cycle"); // R9
  AST_BUSY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (fill_valid_o || fault_o)) else $error("busy dropped without result"); // R1
  AST_NO_REQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_valid_o) else $error("memory request while idle"); // R4
  AST_RSP_IN_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rsp_valid_i |-> (st_q == ST_WAIT)) else $error("response without outstanding read"); // R4
endmodule

// File: rtl/page_walker.sv
module page_walker
  import ptw_pkg::*;
#(
  parameter int VA_W         = ptw_pkg::VA_W,
  parameter int PPN_W        = ptw_pkg::PPN_W,
  parameter int OFF_W        = ptw_pkg::OFF_W,
  parameter int PTE_W        = ptw_pkg::PTE_W,
  parameter int LEVELS       = ptw_pkg::LEVELS,
  parameter int IDX_W        = ptw_pkg::IDX_W,
  localparam int PA_W        = PPN_W + OFF_W,
  localparam int LVL_W       = $clog2(LEVELS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_va_i,
  input  logic [PPN_W-1:0] root_ppn_i,
  output logic             req_ready_o,
  output logic             busy_o,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic             mem_req_we_o,
  output logic [PA_W-1:0]  mem_req_addr_o,
  output logic [PTE_W-1:0] mem_req_wdata_o,
  input  logic             mem_rsp_valid_i,
  input  logic [PTE_W-1:0] mem_rsp_data_i,
  output logic             fill_valid_o,
  output logic [VA_W-1:0]  fill_va_o,
  output logic [PPN_W-1:0] fill_ppn_o,
  output logic [PA_W-1:0]  fill_pa_o,
  output logic             fault_o,
  output logic [LVL_W-1:0] fault_level_o
);
  logic             present, accessed;
  logic [PPN_W-1:0] next_ppn, base_ppn;
  logic [PTE_W-1:0] marked;
  logic [VA_W-1:0]  va_q;
  logic [LVL_W-1:0] level;

  ptw_pte_dec #(
    .PTE_W(PTE_W), .PPN_W(PPN_W), .OFF_W(OFF_W),
    .PRESENT_BIT(PRESENT_BIT), .ACCESSED_BIT(ACCESSED_BIT)
  ) u_dec (
    .pte_i(mem_rsp_data_i), .present_o(present), .accessed_o(accessed),
    .next_ppn_o(next_ppn), .marked_o(marked)
  );

  ptw_addr_gen #(
    .PA_W(PA_W), .PPN_W(PPN_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
    .LEVELS(LEVELS), .PTE_BYTES_LG(PTE_BYTES_LG)
  ) u_addr (
    .vpn_i(va_q[OFF_W+IDX_W*LEVELS-1:OFF_W]), .level_i(level),
    .base_ppn_i(base_ppn), .addr_o(mem_req_addr_o)
  );

  ptw_ctrl #(
    .VA_W(VA_W), .PPN_W(PPN_W), .PTE_W(PTE_W), .LEVELS(LEVELS)
  ) u_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_va_i, .root_ppn_i,
    .req_ready_o, .busy_o, .mem_req_valid_o, .mem_req_ready_i, .mem_req_we_o,
    .mem_rsp_valid_i,
    .pte_present_i(present), .pte_accessed_i(accessed),
    .pte_next_ppn_i(next_ppn), .pte_marked_i(marked),
    .wdata_o(mem_req_wdata_o), .va_o(va_q), .level_o(level), .base_o(base_ppn),
    .fill_valid_o, .fill_ppn_o, .fault_o, .fault_level_o
  );

  assign fill_va_o = va_q;
  assign fill_pa_o = {fill_ppn_o, va_q[OFF_W-1:0]};

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=>
      (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_we_o)
       && $stable(mem_req_wdata_o))) else $error("request changed while stalled"); // R8
  AST_WB_MARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && mem_req_we_o) |->
      (mem_req_wdata_o[ACCESSED_BIT] && mem_req_wdata_o[PRESENT_BIT]))
    else $error("write-back data lacks flags"); // R7
  AST_WB_THEN_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && mem_req_we_o && mem_req_ready_i) |=> fill_valid_o)
    else $error("write-back not followed by fill"); // R7
endmodule

// File: tb/page_walker_tb.sv
module page_walker_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        req_valid_i;
  logic [47:0] req_va_i;
  logic [39:0] root_ppn_i;
  logic        req_ready_o, busy_o;
  logic        mem_req_valid_o, mem_req_ready_i, mem_req_we_o;
  logic [51:0] mem_req_addr_o;
  logic [63:0] mem_req_wdata_o;
  logic        mem_rsp_valid_i;
  logic [63:0] mem_rsp_data_i;
  logic        fill_valid_o, fault_o;
  logic [47:0] fill_va_o;
  logic [39:0] fill_ppn_o;
  logic [51:0] fill_pa_o;
  logic [1:0]  fault_level_o;

  page_walker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i, .req_va_i, .root_ppn_i,
    .req_ready_o, .busy_o, .mem_req_valid_o, .mem_req_ready_i, .mem_req_we_o,
    .mem_req_addr_o, .mem_req_wdata_o, .mem_rsp_valid_i, .mem_rsp_data_i,
    .fill_valid_o, .fill_va_o, .fill_ppn_o, .fill_pa_o, .fault_o, .fault_level_o
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  int  checks = 0, errors = 0;
  bit  finished = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model and port monitor
  logic [63:0] pmem [logic [51:0]];
  logic [51:0] rd_log [$];
  int          wr_cnt, wr_cyc, fill_cyc, cyc;
  logic [51:0] wr_addr, pend_addr, prev_addr, fill_pa_s;
  logic [63:0] wr_data, prev_wdata;
  logic [47:0] fill_va_s;
  logic [39:0] fill_ppn_s;
  logic [1:0]  fault_lvl_s;
  bit fill_seen, fault_seen, busy_at_pulse, hold_err, overlap_err, busy_err;
  bit pend, prev_stall, prev_we;
  int pend_cnt;

  initial begin
    mem_req_ready_i = 1'b0;
    mem_rsp_valid_i = 1'b0;
    mem_rsp_data_i  = '0;
    cyc = 0; pend = 0; prev_stall = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        mem_rsp_valid_i = 1'b0;
        if (pend) begin
          if (pend_cnt == 0) begin
            mem_rsp_valid_i = 1'b1;
            mem_rsp_data_i  = pmem.exists(pend_addr) ? pmem[pend_addr] : 64'h0;
            pend = 0;
          end else pend_cnt--;
        end
        if (prev_stall && !(mem_req_valid_o && mem_req_addr_o == prev_addr &&
            mem_req_we_o == prev_we && mem_req_wdata_o == prev_wdata)) hold_err = 1;
        if (busy_o && req_ready_o) busy_err = 1;
        if (fill_valid_o) begin
          fill_seen = 1; fill_cyc = cyc; fill_ppn_s = fill_ppn_o;
          fill_pa_s = fill_pa_o; fill_va_s = fill_va_o; busy_at_pulse = busy_o;
        end
        if (fault_o) begin
          fault_seen = 1; fault_lvl_s = fault_level_o; busy_at_pulse = busy_o;
        end
        mem_req_ready_i = ($urandom_range(0, 3) != 0);
        prev_stall = 0;
        if (mem_req_valid_o) begin
          if (mem_req_ready_i) begin
            if (mem_req_we_o) begin
              wr_cnt++; wr_addr = mem_req_addr_o; wr_data = mem_req_wdata_o;
              wr_cyc = cyc; pmem[mem_req_addr_o] = mem_req_wdata_o;
            end else begin
              if (pend || mem_rsp_valid_i) overlap_err = 1;
              rd_log.push_back(mem_req_addr_o);
              pend = 1; pend_addr = mem_req_addr_o; pend_cnt = $urandom_range(0, 2);
            end
          end else begin
            prev_stall = 1; prev_addr = mem_req_addr_o;
            prev_we = mem_req_we_o; prev_wdata = mem_req_wdata_o;
          end
        end
      end
    end
  end

  function automatic logic [8:0] idx_of(logic [47:0] va, int l);
    return va[47-9*l -: 9];
  endfunction

  function automatic logic [51:0] ent_addr(logic [39:0] base, logic [8:0] idx);
    return {base, 12'h000} + {40'h0, idx, 3'b000};
  endfunction

  // fault_at: level with clear present bit, 4 = none
  task automatic run_walk(input logic [47:0] va, input logic [39:0] root,
                          input int fault_at, input bit a_set);
    logic [39:0] bases [5];
    logic [51:0] exp_addr [4];
    logic [63:0] leaf;
    int nrd, t;
    pmem.delete(); rd_log.delete();
    wr_cnt = 0; fill_seen = 0; fault_seen = 0;
    hold_err = 0; overlap_err = 0; busy_err = 0; busy_at_pulse = 1;
    bases[0] = root;
    for (int l = 0; l < 4; l++) begin
      logic [63:0] pte;
      bases[l+1]  = {$urandom(), $urandom()} ;
      exp_addr[l] = ent_addr(bases[l], idx_of(va, l));
      pte = {$urandom(), $urandom()};
      pte[51:12] = bases[l+1];
      pte[0] = (l != fault_at);
      if (l == 3) pte[5] = a_set;
      if (l == 3) leaf = pte;
      pmem[exp_addr[l]] = pte;
    end
    @(negedge clk);
    req_valid_i = 1'b1; req_va_i = va; root_ppn_i = root;
    while (!req_ready_o) @(negedge clk);
    @(negedge clk);
    req_valid_i = 1'b0; req_va_i = ~va; root_ppn_i = ~root;
    check(busy_o == 1'b1, "R1 busy after accept", 64'(busy_o), 64'h1);
    t = 0;
    while (!fill_seen && !fault_seen && t < 400) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    nrd = (fault_at < 4) ? fault_at + 1 : 4;
    check(rd_log.size() == nrd, (fault_at < 4) ? "R6 read count" : "R4 read count",
          64'(rd_log.size()), 64'(nrd));
    for (int i = 0; i < nrd && i < rd_log.size(); i++)
      check(rd_log[i] == exp_addr[i], (i == 0) ? "R2 root read addr" : "R3 level read addr",
            64'(rd_log[i]), 64'(exp_addr[i]));
    if (fault_at < 4) begin
      check(fault_seen, "R6 fault pulse", 64'(fault_seen), 64'h1);
      check(fault_lvl_s == 2'(fault_at), "R6 fault level", 64'(fault_lvl_s), 64'(fault_at));
      check(!fill_seen, "R6 no fill on fault", 64'(fill_seen), 64'h0);
      check(wr_cnt == 0, "R6 no write on fault", 64'(wr_cnt), 64'h0);
    end else begin
      check(fill_seen, "R5 fill pulse", 64'(fill_seen), 64'h1);
      check(!fault_seen, "R9 no fault with fill", 64'(fault_seen), 64'h0);
      check(fill_ppn_s == bases[4], "R5 fill ppn", 64'(fill_ppn_s), 64'(bases[4]));
      check(fill_pa_s == {bases[4], va[11:0]}, "R5 fill pa", 64'(fill_pa_s),
            64'({bases[4], va[11:0]}));
      check(fill_va_s == va, "R5 fill va", 64'(fill_va_s), 64'(va));
      check(wr_cnt == (a_set ? 0 : 1), "R7 write count", 64'(wr_cnt), a_set ? 64'h0 : 64'h1);
      if (!a_set && wr_cnt == 1) begin
        check(wr_addr == exp_addr[3], "R7 write addr", 64'(wr_addr), 64'(exp_addr[3]));
        check(wr_data == (leaf | 64'h20), "R7 write data", wr_data, leaf | 64'h20);
        check(wr_cyc < fill_cyc, "R7 write before fill", 64'(wr_cyc), 64'(fill_cyc));
      end
    end
    check(!busy_at_pulse, "R1 busy low at pulse", 64'(busy_at_pulse), 64'h0);
    check(!busy_err, "R1 ready while busy", 64'(busy_err), 64'h0);
    check(!hold_err, "R8 stalled request changed", 64'(hold_err), 64'h0);
    check(!overlap_err, "R4 two reads outstanding", 64'(overlap_err), 64'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; req_valid_i = 1'b0; req_va_i = '0; root_ppn_i = '0;
    repeat (3) @(negedge clk);
    check(req_ready_o == 1'b1, "R1 reset ready", 64'(req_ready_o), 64'h1);
    check(busy_o == 1'b0, "R1 reset busy", 64'(busy_o), 64'h0);
    check(mem_req_valid_o == 1'b0, "R4 reset no request", 64'(mem_req_valid_o), 64'h0);
    check(!fill_valid_o && !fault_o, "R9 reset pulses low", 64'({fill_valid_o, fault_o}), 64'h0);
    rst_n = 1'b1;
    // directed corners
    run_walk(48'h0000_0000_0000, 40'h0, 4, 0);
    run_walk(48'hFFFF_FFFF_FFFF, 40'hFF_FFFF_FFFF, 4, 0);
    run_walk(48'h1234_5678_9ABC, 40'h12_3456, 4, 1);
    for (int k = 0; k < 4; k++) run_walk({$urandom(), $urandom()}, {$urandom(), $urandom()}, k, 0);
    // random mix
    for (int n = 0; n < 60; n++) begin
      int f = $urandom_range(0, 7);
      run_walk({$urandom(), $urandom()}, {$urandom(), $urandom()}, (f < 4) ? f : 4,
               bit'($urandom_range(0, 1)));
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule